// File: doc/BRIEF.md
# Indexed Literal Offset Execution Unit

This block executes three data-memory instructions whose operand address is a frame pointer plus a short literal offset: add the working register to an indexed byte, set one bit of an indexed byte, and fill an indexed byte with all ones. It takes a 16-bit instruction word, a mode enable that turns on the pointer-relative interpretation, and the current frame pointer. It drives a byte-wide read/write port into data memory, and it holds the working register (W) and the five arithmetic status flags.

Every instruction takes one instruction cycle of four clocks, and the phases always come in this order: decode, operand read, process, write-back. The unit samples the instruction, mode and pointer during the decode phase. It reads memory in the read phase and computes in the process phase. It commits results to memory, W and the flags only in the write-back phase. A word that is not one of the three forms, or any word while the mode is off, runs as a four-clock no-op.

Top module: `ilo_exec_unit`

## Requirements
- R1: The `phase` output steps 0 (decode), 1 (read), 2 (process), 3 (write-back), then returns to 0, one step per clock. `instr`, `ext_en` and `frame_ptr` are sampled in phase 0. W and the flags change only at the clock edge that ends phase 3.
- R2: The effective address is (`frame_ptr` + k) mod 2^ADDR_W, where k is `instr[7:0]`. This address is on `mem_addr` during the read and the write-back of a valid instruction.
- R3: Add with `instr[15:10]`=001001, `instr[8]`=0 and d=`instr[9]`=0 loads W with W + mem[EA] (mod 256) and leaves memory unchanged.
- R4: The same add with d=1 writes W + mem[EA] to mem[EA] and leaves W unchanged.
- R5: After an add, `status` = {N, OV, Z, DC, C} in bits 4..0. C is the carry out of bit 7, DC is the carry out of bit 3, OV is two's-complement overflow, Z is set when the 8-bit sum is zero, and N is bit 7 of the sum.
- R6: Bit set (`instr[15:12]`=1000, `instr[8]`=0, b=`instr[11:9]`) writes mem[EA] with bit b set and every other bit unchanged.
- R7: Fill (`instr[15:8]`=68h) writes FFh to mem[EA].
- R8: Bit set and fill leave W and `status` unchanged.
- R9: With `ext_en`=0, every instruction is a no-op: no read, no write, and W and `status` are unchanged.
- R10: An offset k of 60h or more makes the instruction a no-op.
- R11: A word that matches none of the three encodings, including one with `instr[8]`=1, is a no-op.
- R12: `mem_we` is asserted only in phase 3 and only once per writing instruction. `mem_re` is asserted only in phase 1.
- R13: While reset is applied, or after it is applied in the middle of an instruction, `phase`, W and `status` are 0 and `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 16 | Instruction word, sampled in phase 0 |
| ext_en | input | 1 | Enables the pointer-relative interpretation |
| frame_ptr | input | ADDR_W | Frame pointer, sampled in phase 0 |
| mem_addr | output | ADDR_W | Data-memory address |
| mem_re | output | 1 | Read strobe (phase 1) |
| mem_rdata | input | 8 | Read data, combinational from mem_addr |
| mem_we | output | 1 | Write strobe (phase 3) |
| mem_wdata | output | 8 | Write data |
| w_reg | output | 8 | Working register |
| status | output | 5 | {N, OV, Z, DC, C} |
| phase | output | 2 | Current phase 0..3 |

## Verification
The hardest cases to reach are the two wrap-arounds, because they need particular pointer and data values. One is the address wrap, where pointer plus offset passes the top of the 12-bit space. The other is the add whose flags all depend on the carry chain: a zero result with both carries, and a signed overflow into a negative value. W cannot be loaded directly, so before each vector the stimulus runs an add from a scratch byte holding (target − current W). This brings W to any chosen value, and the vector then applies the pointer and offset that cross 0xFFF. Each vector is also checked for writes outside phase 3 and for a read or write on a no-op.

// File: rtl/ilo_pkg.sv
package ilo_pkg;

  localparam int DATA_W = 8;
  localparam int INSN_W = 16;

  typedef enum logic [1:0] {
    PH_DEC  = 2'd0,
    PH_RD   = 2'd1,
    PH_PROC = 2'd2,
    PH_WR   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ADD  = 2'd1,
    OP_BSET = 2'd2,
    OP_FILL = 2'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  typedef struct packed {
    op_e               op;
    logic              to_mem;
    logic [2:0]        bit_sel;
    logic [DATA_W-1:0] ofs;
  } dec_t;

endpackage

// File: rtl/ilo_phase_seq.sv
module ilo_phase_seq
  import ilo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);

  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    ph_d = phase_e'(2'(ph_q) + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_DEC;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  // R1: the write-back phase is always followed by decode
  p_wrap_to_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WR) |=> (ph_q == PH_DEC));

  // R1: decode is always followed by the read phase
  p_decode_to_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DEC) |=> (ph_q == PH_RD));

endmodule

// File: rtl/ilo_decode.sv
module ilo_decode
  import ilo_pkg::*;
#(
  parameter int OFS_LIMIT = 96
)(
  input  logic [INSN_W-1:0] instr,
  input  logic              ext_en,
  output dec_t              dec_o
);

  logic ofs_ok;
  logic is_add;
  logic is_bset;
  logic is_fill;

  always_comb begin
    ofs_ok  = (32'(instr[7:0]) < OFS_LIMIT);
    is_add  = (instr[15:10] == 6'b001001) && !instr[8];
    is_bset = (instr[15:12] == 4'b1000)   && !instr[8];
    is_fill = (instr[15:8]  == 8'h68);

    dec_o.to_mem  = 1'b0;
    dec_o.bit_sel = instr[11:9];
    dec_o.ofs     = instr[7:0];
    dec_o.op      = OP_NOP;

    if (ext_en && ofs_ok) begin
      if (is_add) begin
        dec_o.op     = OP_ADD;
        dec_o.to_mem = instr[9];
      end else if (is_bset) begin
        dec_o.op     = OP_BSET;
        dec_o.to_mem = 1'b1;
      end else if (is_fill) begin
        dec_o.op     = OP_FILL;
        dec_o.to_mem = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ilo_agen.sv
module ilo_agen
  import ilo_pkg::*;
#(
  parameter int ADDR_W = 12
)(
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] ofs,
  output logic [ADDR_W-1:0] ea
);

  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ofs_ext = {{PAD_W{1'b0}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[ADDR_W-1:0];
    end
  endgenerate

  // modulo 2^ADDR_W by truncation of the sum
  assign ea = base + ofs_ext;

endmodule

// File: rtl/ilo_alu.sv
module ilo_alu
  import ilo_pkg::*;
(
  input  op_e               op,
  input  logic [2:0]        bit_sel,
  input  logic [DATA_W-1:0] w_val,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output flags_t            flags
);

  localparam int LO_W = DATA_W / 2;

  logic [DATA_W-1:0] mask;
  logic [DATA_W:0]   sum_full;
  logic [LO_W:0]     sum_lo;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign mask[gi] = (32'(bit_sel) == gi);
    end
  endgenerate

  always_comb begin
    sum_full = {1'b0, w_val} + {1'b0, opnd};
    sum_lo   = {1'b0, w_val[LO_W-1:0]} + {1'b0, opnd[LO_W-1:0]};

    flags.c  = sum_full[DATA_W];
    flags.dc = sum_lo[LO_W];
    flags.n  = sum_full[DATA_W-1];
    flags.z  = (sum_full[DATA_W-1:0] == '0);
    flags.ov = (w_val[DATA_W-1] == opnd[DATA_W-1]) &&
               (sum_full[DATA_W-1] != w_val[DATA_W-1]);

    unique case (op)
      OP_ADD:  result = sum_full[DATA_W-1:0];
      OP_BSET: result = opnd | mask;
      OP_FILL: result = '1;
      default: result = opnd;
    endcase
  end

endmodule

// File: rtl/ilo_exec_unit.sv
module ilo_exec_unit
  import ilo_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OFS_LIMIT   = 96,
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr,
  input  logic              ext_en,
  input  logic [ADDR_W-1:0] frame_ptr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        w_reg,
  output logic [4:0]        status,
  output logic [1:0]        phase
);

  // ---------------- reset: async assert, sync release ----------------
  logic rst_s_n;
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_s_n = sync_q[SYNC_STAGES-1];

  // ---------------- phase sequencer ----------------
  phase_e ph;

  ilo_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .phase_o (ph)
  );

  logic en_dec, en_rd, en_proc, en_wr;
  assign en_dec  = (ph == PH_DEC);
  assign en_rd   = (ph == PH_RD);
  assign en_proc = (ph == PH_PROC);
  assign en_wr   = (ph == PH_WR);

  // ---------------- decode and address generation ----------------
  dec_t              dec_w, dec_q;
  logic [ADDR_W-1:0] ea_w, ea_q;

  ilo_decode #(.OFS_LIMIT(OFS_LIMIT)) u_dec (
    .instr  (instr),
    .ext_en (ext_en),
    .dec_o  (dec_w)
  );

  ilo_agen #(.ADDR_W(ADDR_W)) u_agen (
    .base (frame_ptr),
    .ofs  (dec_w.ofs),
    .ea   (ea_w)
  );

  // ---------------- data path ----------------
  logic [7:0] w_q, w_d;
  flags_t     flg_q, flg_d;
  logic [7:0] opnd_q, opnd_d;
  logic [7:0] res_q, res_d, res_w;
  flags_t     fs_q, fs_d, fs_w;
  dec_t       dec_d;
  logic [ADDR_W-1:0] ea_d;
  logic       valid_op;
  logic       writes_mem;

  assign valid_op   = (dec_q.op != OP_NOP);
  assign writes_mem = valid_op && dec_q.to_mem;

  ilo_alu u_alu (
    .op      (dec_q.op),
    .bit_sel (dec_q.bit_sel),
    .w_val   (w_q),
    .opnd    (opnd_q),
    .result  (res_w),
    .flags   (fs_w)
  );

  // next-state logic, clock enables per phase
  always_comb begin
    dec_d  = dec_q;
    ea_d   = ea_q;
    opnd_d = opnd_q;
    res_d  = res_q;
    fs_d   = fs_q;
    w_d    = w_q;
    flg_d  = flg_q;

    if (en_dec) begin
      dec_d = dec_w;
      ea_d  = ea_w;
    end
    if (en_rd && valid_op) begin
      opnd_d = mem_rdata;
    end
    if (en_proc) begin
      res_d = res_w;
      fs_d  = fs_w;
    end
    if (en_wr && (dec_q.op == OP_ADD)) begin
      flg_d = fs_q;
      if (!dec_q.to_mem) w_d = res_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dec_q  <= '0;
      ea_q   <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      fs_q   <= '0;
      w_q    <= '0;
      flg_q  <= '0;
    end else begin
      dec_q  <= dec_d;
      ea_q   <= ea_d;
      opnd_q <= opnd_d;
      res_q  <= res_d;
      fs_q   <= fs_d;
      w_q    <= w_d;
      flg_q  <= flg_d;
    end
  end

  // ---------------- memory port ----------------
  assign mem_re    = en_rd && valid_op;
  assign mem_we    = en_wr && writes_mem;
  assign mem_addr  = (mem_re || mem_we) ? ea_q : '0;
  assign mem_wdata = mem_we ? res_q : '0;

  assign w_reg  = w_q;
  assign status = flg_q;
  assign phase  = ph;

  // ---------------- assertions ----------------
  // R12: stores only happen in the write-back phase
  p_store_in_wb_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> (phase == 2'd3));

  // R12: loads only happen in the read phase
  p_load_in_rd_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_re |-> (phase == 2'd1));

  // R1: W holds its value outside the write-back phase
  p_w_hold_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase != 2'd3) |=> $stable(w_reg));

  // R8: only the add may touch the flags
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((phase == 2'd3) && (dec_q.op != OP_ADD)) |=> $stable(status));

  // R9: a no-op never touches memory
  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dec_q.op == OP_NOP) |-> (!mem_we && !mem_re));

  // R1: the decoded operation is frozen from read through write-back
  p_dec_frozen_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase != 2'd0) |=> $stable(dec_q));

endmodule

// File: tb/ilo_exec_unit_tb.sv
module ilo_exec_unit_tb;

  localparam int AW = 12;

  logic          clk;
  logic          rst_n;
  logic [15:0]   instr;
  logic          ext_en;
  logic [AW-1:0] frame_ptr;
  logic [AW-1:0] mem_addr;
  logic          mem_re;
  logic [7:0]    mem_rdata;
  logic          mem_we;
  logic [7:0]    mem_wdata;
  logic [7:0]    w_reg;
  logic [4:0]    status;
  logic [1:0]    phase;

  ilo_exec_unit u_dut (
    .clk (clk), .rst_n (rst_n), .instr (instr), .ext_en (ext_en),
    .frame_ptr (frame_ptr), .mem_addr (mem_addr), .mem_re (mem_re),
    .mem_rdata (mem_rdata), .mem_we (mem_we), .mem_wdata (mem_wdata),
    .w_reg (w_reg), .status (status), .phase (phase)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- memory model ----------------
  logic [7:0]    mem [1 << AW];
  int            wr_cnt, rd_cnt, bad_phase;
  logic [AW-1:0] wr_addr, rd_addr;

  assign mem_rdata = mem[mem_addr];

  always @(negedge clk) begin
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wr_cnt  = wr_cnt + 1;
      wr_addr = mem_addr;
      if (phase != 2'd3) bad_phase = bad_phase + 1;
    end
    if (mem_re) begin
      rd_cnt  = rd_cnt + 1;
      rd_addr = mem_addr;
      if (phase != 2'd1) bad_phase = bad_phase + 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int  n_chk;
  int  n_fail;
  bit  done;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [15:0] ins;
    logic        ext;
    logic [11:0] ptr;
    logic [11:0] ea;
    logic [7:0]  mpre;
    logic [7:0]  wpre;
    logic [7:0]  ew;
    logic [4:0]  ef;
    logic [7:0]  emem;
    logic        is_add;
    logic        wr;
    logic        valid;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h242C, 1'b1, 12'hA00, 12'hA2C, 8'h20, 8'h17, 8'h37, 5'h00, 8'h20, 1'b1, 1'b0, 1'b1, 4'd3},  // R3
    '{16'h2605, 1'b1, 12'h123, 12'h128, 8'h0F, 8'h01, 8'h01, 5'h02, 8'h10, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 DC
    '{16'h2400, 1'b1, 12'h050, 12'h050, 8'h80, 8'h80, 8'h00, 5'h0D, 8'h80, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 OV Z C
    '{16'h245F, 1'b1, 12'hFF0, 12'h04F, 8'h7F, 8'h01, 8'h80, 5'h1A, 8'h7F, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 wrap, R5
    '{16'h2610, 1'b1, 12'h200, 12'h210, 8'hFF, 8'hFF, 8'hFF, 5'h13, 8'hFE, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 N C DC
    '{16'h2401, 1'b1, 12'h700, 12'h701, 8'hF8, 8'h08, 8'h00, 5'h07, 8'hF8, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 Z DC C
    '{16'h8E0A, 1'b1, 12'hA00, 12'hA0A, 8'h55, 8'h33, 8'h33, 5'h00, 8'hD5, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 b=7
    '{16'h8003, 1'b1, 12'h300, 12'h303, 8'hFE, 8'h44, 8'h44, 5'h00, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 b=0
    '{16'h8620, 1'b1, 12'h000, 12'h020, 8'h08, 8'h00, 8'h00, 5'h00, 8'h08, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 R6 b=3
    '{16'h682C, 1'b1, 12'hA00, 12'hA2C, 8'h00, 8'h5A, 8'h5A, 5'h00, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd7},  // R7
    '{16'h685F, 1'b1, 12'hFFF, 12'h05E, 8'h12, 8'hC3, 8'hC3, 5'h00, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 R2 wrap
    '{16'h242C, 1'b0, 12'hA00, 12'hA2C, 8'h20, 8'h17, 8'h17, 5'h00, 8'h20, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{16'h6810, 1'b0, 12'h400, 12'h410, 8'h77, 8'h99, 8'h99, 5'h00, 8'h77, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{16'h2460, 1'b1, 12'hA00, 12'hA60, 8'h11, 8'h22, 8'h22, 5'h00, 8'h11, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{16'h2500, 1'b1, 12'h100, 12'h100, 8'h33, 8'h10, 8'h10, 5'h00, 8'h33, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{16'h8105, 1'b1, 12'h200, 12'h205, 8'h00, 8'h10, 8'h10, 5'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd11}  // R11
  };

  // ---------------- stimulus helpers ----------------
  logic [7:0] hold_bad;

  // runs one instruction; returns with phase back at 0 after commit
  task automatic exec(input logic [15:0] ins, input logic ext, input logic [AW-1:0] ptr);
    logic [7:0] w0;
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
    instr = ins; ext_en = ext; frame_ptr = ptr;
    wr_cnt = 0; rd_cnt = 0; hold_bad = 0;
    w0 = w_reg;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (w_reg != w0) hold_bad = hold_bad + 1;   // R1: no commit before phase 3 ends
    end
    @(negedge clk);
    instr = 16'h0000; frame_ptr = '0;
  endtask

  task automatic set_w(input logic [7:0] target);
    mem[12'hE00] = target - w_reg;
    exec(16'h2400, 1'b1, 12'hE00);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    wr_cnt = 0; rd_cnt = 0; bad_phase = 0; wr_addr = '0; rd_addr = '0;
    instr = '0; ext_en = 1'b0; frame_ptr = '0;
    for (int a = 0; a < (1 << AW); a++) mem[a] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R13: reset state
    check(phase == 2'd0, "R13", "phase in reset", phase, 0);
    check(w_reg == 8'h00, "R13", "W in reset", w_reg, 0);
    check(status == 5'h00, "R13", "status in reset", status, 0);
    check(!mem_we && !mem_re, "R13", "strobes in reset", {mem_we, mem_re}, 0);

    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [4:0] f0;
      logic [7:0] m_after;
      set_w(VECS[v].wpre);
      check(w_reg == VECS[v].wpre, "R3", "W preload", w_reg, VECS[v].wpre);
      mem[VECS[v].ea] = VECS[v].mpre;
      f0 = status;
      exec(VECS[v].ins, VECS[v].ext, VECS[v].ptr);
      m_after = mem[VECS[v].ea];
      check(w_reg == VECS[v].ew, $sformatf("R%0d", VECS[v].req), "W", w_reg, VECS[v].ew);
      if (VECS[v].is_add)
        check(status == VECS[v].ef, $sformatf("R%0d", VECS[v].req), "flags", status, VECS[v].ef);
      else
        check(status == f0, "R8", "flags unchanged", status, f0);
      check(m_after == VECS[v].emem, $sformatf("R%0d", VECS[v].req), "memory", m_after, VECS[v].emem);
      check(wr_cnt == (VECS[v].wr ? 1 : 0), "R12", "write count", wr_cnt, VECS[v].wr ? 1 : 0);
      check(rd_cnt == (VECS[v].valid ? 1 : 0), "R9", "read count", rd_cnt, VECS[v].valid ? 1 : 0);
      if (VECS[v].valid)
        check(rd_addr == VECS[v].ea, "R2", "read address", rd_addr, VECS[v].ea);
      if (VECS[v].wr)
        check(wr_addr == VECS[v].ea, "R2", "write address", wr_addr, VECS[v].ea);
      check(hold_bad == 0, "R1", "W changed early", hold_bad, 0);
    end

    check(bad_phase == 0, "R12", "strobe outside its phase", bad_phase, 0);

    // R1: phase order over one instruction cycle
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
    for (int p = 1; p < 5; p++) begin
      @(negedge clk);
      check(phase == 2'(p), "R1", "phase order", phase, p % 4);
    end

    // R13: reset in the middle of an instruction
    mem[12'h333] = 8'h40;
    set_w(8'h21);
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
    instr = 16'h2433; ext_en = 1'b1; frame_ptr = 12'h300;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(phase == 2'd0, "R13", "phase after mid reset", phase, 0);
    check(w_reg == 8'h00, "R13", "W after mid reset", w_reg, 0);
    check(status == 5'h00, "R13", "status after mid reset", status, 0);
    check(!mem_we && !mem_re, "R13", "strobes after mid reset", {mem_we, mem_re}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem[12'h333] == 8'h40, "R13", "memory after mid reset", mem[12'h333], 8'h40);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule